// File: doc/BRIEF.md
# Serial Receive Unit with Error Flags

This block turns an asynchronous serial line into characters. The line is first brought into the clock domain by a short synchronizer. A programmable divider then produces an oversampling tick at sixteen times the bit rate. A falling edge on the idle line opens a frame. The frame is kept only if the line is still low at the middle of the start bit. After that, every later bit is sampled once at its midpoint.

The character length can be 7, 8 or 9 bits, parity can be off, even or odd, and a frame can end with one or two stop bits. These settings must match those of the far-end transmitter and stay fixed during a frame. When the last stop bit has been sampled, the assembled character moves into a one-entry receive buffer and a one-cycle interrupt pulse is raised. The buffer then holds the character with its framing and parity status until a read strobe empties it.

An overrun is declared at one exact point: a second frame reaches the bit just before its final stop bit while the buffer is still unread. An error-sum output combines all three error flags.

Top module: `srx_receiver`

## Requirements
- R1: After reset the data output is zero, and the full, overrun, framing, parity, error-sum and interrupt outputs are all low.
- R2: A frame opens only on a high-to-low transition of the synchronized line, seen on an oversample tick. The line must still be low 8 ticks later. If it is high at that point, the frame is dropped as a glitch: nothing is loaded and no interrupt is raised.
- R3: The character-length code sets the length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, 2'b10 gives 9 bits, and 2'b11 is treated as 8 bits. Bits arrive least significant first and appear right-aligned on the 9-bit data output. Unused upper bits read as zero.
- R4: With parity enabled, a parity error is reported for a character when the total number of ones in its data bits and its parity bit is odd (for even parity) or even (for odd parity). With parity disabled, no parity bit is expected and the parity flag loads as zero.
- R5: The framing flag loads as one when any of the configured stop bits (one or two) is sampled low.
- R6: Each character that moves into the buffer produces a single-cycle interrupt pulse, and the full output is high in that same cycle.
- R7: The overrun flag is set when the buffer is still full at the sample of the bit just before the final stop bit of the next frame. That bit is the first stop bit when two stop bits are configured. Otherwise it is the parity bit, or the last data bit when parity is off. The flag is not set earlier.
- R8: A frame that caused an overrun is not loaded. It raises no interrupt, and the data, framing and parity outputs keep the values of the previous character.
- R9: A read strobe clears the full and overrun outputs on the next edge. A load or an overrun set in the same cycle takes priority over the strobe.
- R10: The error-sum output is high exactly when at least one of the overrun, framing or parity flags is high.
- R11: While receive enable is low, no frame is received and the buffer is left untouched.
- R12: The oversample tick fires once every baud_div+1 clock cycles, so one bit lasts 16*(baud_div+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input line, idles high |
| rx_en | input | 1 | Receive enable |
| char_len | input | 2 | Character length code (R3) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop2 | input | 1 | 1 selects two stop bits |
| baud_div | input | DIV_W | Divider value n; one tick every n+1 clocks |
| rd_strobe | input | 1 | Buffer read, clears full and overrun |
| rx_data | output | 9 | Buffered character |
| rx_full | output | 1 | Buffer holds an unread character |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing flag of buffered character |
| par_err | output | 1 | Parity flag of buffered character |
| err_sum | output | 1 | OR of the three error flags |
| rx_irq | output | 1 | Receive-complete pulse |

## Verification
The line passes through the two-stage synchronizer before any logic sees it. Each mid-bit sample therefore lands about 10 clocks after the bench drives that bit, at one tick per clock. Data, flags and the interrupt follow one edge after the final stop-bit sample, so they are due about 11 clocks into the last stop bit. The overrun flag is due at the same offset inside the bit before the final stop bit. The bench checks every result on a falling clock edge at a bit boundary, 16 ticks after that bit began. This leaves several cycles of margin before the next bit can change anything. Interrupt pulses are counted over the whole frame, so a missing, extra or suppressed pulse is caught no matter which cycle it lands in.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2
   } rx_state_t;

   localparam logic [1:0] LEN7 = 2'b00;
   localparam logic [1:0] LEN8 = 2'b01;
   localparam logic [1:0] LEN9 = 2'b10;

   function automatic logic [3:0] char_bits(input logic [1:0] code);
      case (code)
         LEN7:    return 4'd7;
         LEN9:    return 4'd9;
         default: return 4'd8;
      endcase
   endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_tick.sv
module srx_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("srx_tick: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;

   assign tick = en && (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!en || tick) cnt <= '0;
      else                  cnt <= cnt + DIV_W'(1);
   end

   // R12: with a nonzero divider, two ticks never come back to back
   p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       rx_s,
   input  logic [1:0] char_len,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       stop2,
   input  logic       buf_full,
   output logic       load,
   output logic [8:0] ld_data,
   output logic       ld_fe,
   output logic       ld_pe,
   output logic       ovr_set
);
   generate
      if (OSR < 8 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("srx_frame: OSR must be a power of two, at least 8");
      end
   endgenerate

   localparam int OS_W = $clog2(OSR);
   localparam logic [OS_W-1:0] MID_M1  = OS_W'(OSR / 2 - 1);
   localparam logic [OS_W-1:0] LAST_OS = OS_W'(OSR - 1);

   rx_state_t       state;
   logic [OS_W-1:0] os_cnt;
   logic [3:0]      bit_idx;
   logic [8:0]      shreg;
   logic            par_acc, par_bad, stop_bad, frame_ovr, line_prev;

   logic [3:0] nbits;
   logic       samp, last_data, final_samp, pre_final, mid_start;

   always_comb begin
      nbits      = char_bits(char_len);
      last_data  = (bit_idx == nbits - 4'd1);
      mid_start  = tick && state == ST_START && os_cnt == MID_M1;
      samp       = tick && os_cnt == LAST_OS &&
                   (state inside {ST_DATA, ST_PAR, ST_STOP1, ST_STOP2});
      final_samp = samp && (state == ST_STOP2 || (state == ST_STOP1 && !stop2));
      pre_final  = samp && ((state == ST_STOP1 && stop2) ||
                            (state == ST_PAR && !stop2) ||
                            (state == ST_DATA && last_data && !par_en && !stop2));
      ovr_set    = pre_final && buf_full;
      load       = final_samp && !frame_ovr;
      ld_data    = shreg >> (4'd9 - nbits);
      ld_fe      = stop_bad | !rx_s;
      ld_pe      = par_bad;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         os_cnt    <= '0;
         bit_idx   <= '0;
         shreg     <= '0;
         par_acc   <= 1'b0;
         par_bad   <= 1'b0;
         stop_bad  <= 1'b0;
         frame_ovr <= 1'b0;
         line_prev <= 1'b1;
      end else if (!en) begin
         state     <= ST_IDLE;
         os_cnt    <= '0;
         line_prev <= rx_s;
      end else if (tick) begin
         line_prev <= rx_s;
         case (state)
            ST_IDLE: begin
               if (line_prev && !rx_s) begin
                  state  <= ST_START;
                  os_cnt <= '0;
               end
            end
            ST_START: begin
               if (os_cnt == MID_M1) begin
                  os_cnt <= '0;
                  if (rx_s) begin
                     state <= ST_IDLE;
                  end else begin
                     state     <= ST_DATA;
                     bit_idx   <= '0;
                     shreg     <= '0;
                     par_acc   <= 1'b0;
                     par_bad   <= 1'b0;
                     stop_bad  <= 1'b0;
                     frame_ovr <= 1'b0;
                  end
               end else begin
                  os_cnt <= os_cnt + OS_W'(1);
               end
            end
            default: begin
               if (os_cnt == LAST_OS) begin
                  os_cnt <= '0;
                  if (ovr_set) frame_ovr <= 1'b1;
                  case (state)
                     ST_DATA: begin
                        shreg   <= {rx_s, shreg[8:1]};
                        par_acc <= par_acc ^ rx_s;
                        if (last_data) state <= par_en ? ST_PAR : ST_STOP1;
                        else           bit_idx <= bit_idx + 4'd1;
                     end
                     ST_PAR: begin
                        par_bad <= par_acc ^ rx_s ^ par_odd;
                        state   <= ST_STOP1;
                     end
                     ST_STOP1: begin
                        stop_bad <= !rx_s;
                        state    <= stop2 ? ST_STOP2 : ST_IDLE;
                     end
                     default: state <= ST_IDLE;
                  endcase
               end else begin
                  os_cnt <= os_cnt + OS_W'(1);
               end
            end
         endcase
      end
   end

   // R2: a high line at the start-bit midpoint drops the frame
   p_glitch_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mid_start && rx_s) |=> state == ST_IDLE);

   // R11: disabling reception forces the idle state
   p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> state == ST_IDLE);

   // R3: a 7-bit character leaves the two top bits clear
   p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && char_len == LEN7) |-> ld_data[8:7] == 2'b00);
endmodule

// File: rtl/srx_buffer.sv
module srx_buffer (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [8:0] ld_data,
   input  logic       ld_fe,
   input  logic       ld_pe,
   input  logic       ovr_set,
   input  logic       rd,
   output logic [8:0] data,
   output logic       full,
   output logic       ovr,
   output logic       fe,
   output logic       pe,
   output logic       irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         full <= 1'b0;
         ovr  <= 1'b0;
         fe   <= 1'b0;
         pe   <= 1'b0;
         irq  <= 1'b0;
      end else begin
         irq <= load;
         if (load) begin
            data <= ld_data;
            fe   <= ld_fe;
            pe   <= ld_pe;
            full <= 1'b1;
         end else if (rd) begin
            full <= 1'b0;
         end
         if (ovr_set)  ovr <= 1'b1;
         else if (rd)  ovr <= 1'b0;
      end
   end

   // R6: the interrupt is a single-cycle pulse
   p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R6: the buffer reads full while the interrupt is high
   p_irq_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> full);

   // R7: overrun only rises when the buffer was full
   p_ovr_needs_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(full));

   // R9: an uncontested read empties the buffer and clears overrun
   p_rd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !load && !ovr_set) |=> (!full && !ovr));
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver #(
   parameter int DIV_W       = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rxd,
   input  logic             rx_en,
   input  logic [1:0]       char_len,
   input  logic             par_en,
   input  logic             par_odd,
   input  logic             stop2,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             rd_strobe,
   output logic [8:0]       rx_data,
   output logic             rx_full,
   output logic             ovr_err,
   output logic             frm_err,
   output logic             par_err,
   output logic             err_sum,
   output logic             rx_irq
);
   logic       rx_s, tick, load, ld_fe, ld_pe, ovr_set;
   logic [8:0] ld_data;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
   );

   srx_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .div(baud_div), .tick(tick)
   );

   srx_frame #(.OSR(OSR)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rx_s(rx_s),
      .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
      .buf_full(rx_full), .load(load), .ld_data(ld_data), .ld_fe(ld_fe),
      .ld_pe(ld_pe), .ovr_set(ovr_set)
   );

   srx_buffer u_buf (
      .clk(clk), .rst_n(rst_n), .load(load), .ld_data(ld_data), .ld_fe(ld_fe),
      .ld_pe(ld_pe), .ovr_set(ovr_set), .rd(rd_strobe), .data(rx_data),
      .full(rx_full), .ovr(ovr_err), .fe(frm_err), .pe(par_err), .irq(rx_irq)
   );

   assign err_sum = ovr_err | frm_err | par_err;

   // R10: the error sum follows the overrun flag
   p_sum_covers_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_err |-> err_sum);
endmodule

// File: tb/srx_receiver_test.sv
module srx_receiver_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       rx_en = 1'b1;
   logic [1:0] char_len = 2'b01;
   logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
   logic [7:0] baud_div = 8'd0;
   logic       rd_strobe = 1'b0;
   logic [8:0] rx_data;
   logic       rx_full, ovr_err, frm_err, par_err, err_sum, rx_irq;

   int checks = 0, fails = 0, irq_cnt = 0, bitc = 16;
   bit done = 0;

   always #4 clk = ~clk;

   srx_receiver uut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .char_len(char_len),
      .par_en(par_en), .par_odd(par_odd), .stop2(stop2), .baud_div(baud_div),
      .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
      .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err),
      .err_sum(err_sum), .rx_irq(rx_irq)
   );

   always @(negedge clk) if (rx_irq) irq_cnt++;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive_bit(input logic b, input int n);
      rxd = b;
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_cfg(input logic [1:0] len, input logic pe, input logic po, input logic s2);
      char_len = len; par_en = pe; par_odd = po; stop2 = s2;
   endtask

   task automatic read_buf();
      @(posedge clk); #1 rd_strobe = 1'b1;
      @(posedge clk); #1 rd_strobe = 1'b0;
   endtask

   function automatic int nb_of(input logic [1:0] len);
      return (len == 2'b00) ? 7 : (len == 2'b10) ? 9 : 8;
   endfunction

   // full frame from the current configuration, then two idle bit times
   task automatic send(input logic [8:0] d, input bit flip_par, input bit bad_s1, input bit bad_s2);
      int nb = nb_of(char_len);
      logic p = par_odd;
      drive_bit(1'b0, bitc);
      for (int i = 0; i < nb; i++) begin
         drive_bit(d[i], bitc);
         p = p ^ d[i];
      end
      if (par_en) drive_bit(p ^ flip_par, bitc);
      drive_bit(!bad_s1, bitc);
      if (stop2) drive_bit(!bad_s2, bitc);
      drive_bit(1'b1, 2 * bitc);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "data", rx_data, 0);
      chk("R1", "full", rx_full, 0);
      chk("R1", "flags", {ovr_err, frm_err, par_err, err_sum}, 0);
      chk("R1", "irq", rx_irq, 0);
   endtask

   task automatic t_basic_8n1();
      set_cfg(2'b01, 0, 0, 0);
      irq_cnt = 0;
      send(9'h0A5, 0, 0, 0);
      chk("R6", "irq count 8N1", irq_cnt, 1);
      chk("R6", "full after load", rx_full, 1);
      chk("R3", "data 8N1", rx_data, 9'h0A5);
      chk("R5", "no framing", frm_err, 0);
      chk("R4", "parity off", par_err, 0);
      read_buf();
      @(negedge clk);
      chk("R9", "full cleared", rx_full, 0);
   endtask

   task automatic t_lengths();
      set_cfg(2'b00, 1, 0, 1);
      irq_cnt = 0;
      send(9'h07F, 0, 0, 0);
      chk("R3", "7-bit upper zero", rx_data, 9'h07F);
      chk("R4", "7E2 parity ok", par_err, 0);
      chk("R6", "irq 7E2", irq_cnt, 1);
      read_buf();
      set_cfg(2'b10, 0, 0, 0);
      send(9'h1A3, 0, 0, 0);
      chk("R3", "9-bit data", rx_data, 9'h1A3);
      read_buf();
      set_cfg(2'b11, 0, 0, 0);
      send(9'h05C, 0, 0, 0);
      chk("R3", "code 11 as 8 bits", rx_data, 9'h05C);
      read_buf();
   endtask

   task automatic t_parity();
      set_cfg(2'b01, 1, 0, 0);
      send(9'h0B3, 0, 0, 0);
      chk("R4", "even good", par_err, 0);
      read_buf();
      send(9'h0B3, 1, 0, 0);
      chk("R4", "even bad", par_err, 1);
      chk("R10", "sum on parity", err_sum, 1);
      read_buf();
      set_cfg(2'b01, 1, 1, 0);
      send(9'h0B3, 0, 0, 0);
      chk("R4", "odd good", par_err, 0);
      chk("R10", "sum clear", err_sum, 0);
      read_buf();
      send(9'h0B3, 1, 0, 0);
      chk("R4", "odd bad", par_err, 1);
      read_buf();
   endtask

   task automatic t_framing();
      set_cfg(2'b01, 0, 0, 0);
      send(9'h03C, 0, 1, 0);
      chk("R5", "1 stop low", frm_err, 1);
      chk("R10", "sum on framing", err_sum, 1);
      read_buf();
      set_cfg(2'b01, 0, 0, 1);
      send(9'h03C, 0, 0, 1);
      chk("R5", "2nd stop low", frm_err, 1);
      read_buf();
      send(9'h03C, 0, 1, 0);
      chk("R5", "1st stop low", frm_err, 1);
      read_buf();
      send(9'h03C, 0, 0, 0);
      chk("R5", "2 stops high", frm_err, 0);
      read_buf();
   endtask

   // buffer left full, second frame driven bit by bit
   task automatic t_overrun(input bit two_stop);
      set_cfg(2'b01, 0, 0, two_stop);
      send(9'h011, 0, 0, 0);
      irq_cnt = 0;
      drive_bit(1'b0, bitc);
      for (int i = 0; i < 7; i++) drive_bit(1'b0, bitc);
      @(negedge clk);
      chk("R7", "no overrun before last data", ovr_err, 0);
      drive_bit(1'b1, bitc);
      @(negedge clk);
      chk("R7", two_stop ? "no overrun after last data (2 stop)" : "overrun after last data",
          ovr_err, two_stop ? 0 : 1);
      drive_bit(1'b1, bitc);
      @(negedge clk);
      chk("R7", "overrun by final stop", ovr_err, 1);
      chk("R10", "sum on overrun", err_sum, 1);
      if (two_stop) drive_bit(1'b1, bitc);
      drive_bit(1'b1, 2 * bitc);
      chk("R8", "no irq for overrun frame", irq_cnt, 0);
      chk("R8", "data kept", rx_data, 9'h011);
      read_buf();
      @(negedge clk);
      chk("R9", "overrun cleared", ovr_err, 0);
      chk("R9", "full cleared after overrun", rx_full, 0);
   endtask

   task automatic t_glitch();
      set_cfg(2'b01, 0, 0, 0);
      irq_cnt = 0;
      drive_bit(1'b0, 4);
      drive_bit(1'b1, 2 * bitc);
      chk("R2", "glitch no irq", irq_cnt, 0);
      chk("R2", "glitch no load", rx_full, 0);
      send(9'h0C6, 0, 0, 0);
      chk("R2", "frame after glitch", rx_data, 9'h0C6);
      chk("R2", "one irq after glitch", irq_cnt, 1);
      read_buf();
   endtask

   task automatic t_disabled();
      rx_en = 1'b0;
      irq_cnt = 0;
      send(9'h099, 0, 0, 0);
      chk("R11", "no irq when disabled", irq_cnt, 0);
      chk("R11", "no load when disabled", rx_full, 0);
      chk("R11", "data untouched", rx_data, 9'h0C6);
      rx_en = 1'b1;
      drive_bit(1'b1, bitc);
      send(9'h066, 0, 0, 0);
      chk("R11", "receives after enable", rx_data, 9'h066);
      read_buf();
   endtask

   task automatic t_divider();
      baud_div = 8'd2;
      bitc = 48;
      irq_cnt = 0;
      drive_bit(1'b1, bitc);
      send(9'h0E1, 0, 0, 0);
      chk("R12", "data at div 2", rx_data, 9'h0E1);
      chk("R12", "irq at div 2", irq_cnt, 1);
      read_buf();
      baud_div = 8'd0;
      bitc = 16;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      drive_bit(1'b1, 8);
      t_basic_8n1();
      t_lengths();
      t_parity();
      t_framing();
      t_overrun(0);
      t_overrun(1);
      t_glitch();
      t_disabled();
      t_divider();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule